// File: doc/BRIEF.md
# Saturating Doubling Multiply-Accumulate-High Vector Unit

This unit is one arithmetic stage of a 128-bit vector datapath. It takes a destination vector, which also acts as the accumulator, a source vector and a 32-bit scalar. Each lane forms twice the product of two signed operands. It then adds a third signed operand shifted up by the element width, and can add a half-unit rounding constant. The sum is clamped to the signed range of twice the element width, and the upper half of the clamped value is the lane result. Lanes are 8, 16 or 32 bits wide.

Two routing forms choose where the operands come from. In the scalar-multiplier form, the scalar is the multiplier and the destination lane is the accumulator. In the scalar-addend form, the destination lane is the multiplier and the scalar is the accumulator. A byte-granular predicate decides which lanes are written back. Lanes that are not enabled keep their destination value. A sticky flag records any saturation in an enabled lane. The result and flag are registered one cycle after an input strobe.

Top module: `sat_dbl_mac_hi`

## Requirements
- R1: `lane_sz` selects the element width E: 0 gives 8 bits (16 lanes), 1 gives 16 bits (8 lanes), 2 and 3 both give 32 bits (4 lanes). Lane k occupies vector bits [k*E +: E].
- R2: With `form` = 0, each lane computes W = 2*x*y + (a << E), where x is the source lane, y is the scalar and a is the destination lane, all signed.
- R3: With `form` = 1, x is the source lane, y is the destination lane and a is the scalar, in the same formula.
- R4: With `rnd` = 1, 2^(E-1) is added to W before saturation. With `rnd` = 0, nothing is added.
- R5: If W exceeds 2^(2E-1)-1, the lane gives the largest signed E-bit value. If W is below -2^(2E-1), the lane gives the smallest. Otherwise the lane gives bits [2E-1:E] of W.
- R6: For 32-bit lanes the saturation test applies to the exact total, including rounding. A sum of -2^63-2^31 is returned to -2^63 by rounding, so it does not saturate.
- R7: The scalar operand is the low E bits of `scalar_in`, taken as signed and shared by every lane. Its higher bits have no effect.
- R8: Lane k is enabled by `pred` bit k*E/8, the bit of its lowest byte. The other predicate bits of the lane have no effect. A disabled lane outputs its `dst_in` value unchanged.
- R9: `sat_sticky` is set when an enabled lane saturates during a strobed operation. Only reset clears it. Saturation in a disabled lane leaves it untouched.
- R10: `res_out` and `res_valid` change on the clock edge that samples `in_valid` = 1. In a cycle with `in_valid` = 0, `res_out` holds and `res_valid` is 0 after the next edge.
- R11: Synchronous active-high `rst` clears `res_out`, `res_valid` and `sat_sticky` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| lane_sz | input | 2 | Element width code |
| form | input | 1 | Operand routing form |
| rnd | input | 1 | Rounding enable |
| pred | input | 16 | Per-byte write predicate |
| dst_in | input | 128 | Destination/accumulator vector |
| src_in | input | 128 | Source vector |
| scalar_in | input | 32 | Scalar operand |
| res_out | output | 128 | Merged registered result |
| res_valid | output | 1 | Result strobe |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
The only state is the result register and the sticky flag. A wrong lane width, operand route or clamp therefore shows as a mismatching `res_out` lane one edge after the strobe. A wrongly set or cleared flag shows on `sat_sticky` in that same cycle and then stays visible, because the flag only moves one way. The bench compares every output in every cycle against a behavioural model. This catches faults that appear only in idle cycles, such as a register that does not hold or a strobe that stays high. Directed cases cover the rounding-recovery boundary for 32-bit lanes and saturation in masked lanes, which random data seldom reaches.

// File: rtl/sdmh_pkg.sv
package sdmh_pkg;
    localparam int VEC_W  = 128;
    localparam int SCAL_W = 32;
    localparam int PRED_W = VEC_W / 8;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_B32X = 2'd3
    } lane_sz_e;

    typedef struct packed {
        logic [VEC_W-1:0] res;
        logic             vld;
        logic             stk;
    } sdmh_state_t;
endpackage

// File: rtl/sdmh_lane.sv
module sdmh_lane #(
    parameter int EW = 8
) (
    input  logic signed [EW-1:0] x_i,
    input  logic signed [EW-1:0] y_i,
    input  logic signed [EW-1:0] acc_i,
    input  logic                 rnd_i,
    output logic [EW-1:0]        hi_o,
    output logic                 sat_o
);
    // Two guard bits above the doubled-width range plus one sign bit keep
    // the full sum exact, so a single clamp at the end suffices.
    localparam int WW = 2 * EW + 3;
    localparam logic signed [WW-1:0] POS_LIM = {{4{1'b0}}, {(2*EW-1){1'b1}}};
    localparam logic signed [WW-1:0] NEG_LIM = {{4{1'b1}}, {(2*EW-1){1'b0}}};

    logic signed [2*EW-1:0] mul_w;
    logic signed [WW-1:0]   dbl_w;
    logic signed [WW-1:0]   acc_w;
    logic signed [WW-1:0]   rnd_w;
    logic signed [WW-1:0]   sum_w;

    always_comb begin
        mul_w = x_i * y_i;
        dbl_w = {{2{mul_w[2*EW-1]}}, mul_w, 1'b0};
        acc_w = {{3{acc_i[EW-1]}}, acc_i, {EW{1'b0}}};
        rnd_w = {{(EW+3){1'b0}}, rnd_i, {(EW-1){1'b0}}};
        sum_w = dbl_w + acc_w + rnd_w;
        if (sum_w > POS_LIM) begin
            hi_o  = {1'b0, {(EW-1){1'b1}}};
            sat_o = 1'b1;
        end else if (sum_w < NEG_LIM) begin
            hi_o  = {1'b1, {(EW-1){1'b0}}};
            sat_o = 1'b1;
        end else begin
            hi_o  = sum_w[2*EW-1:EW];
            sat_o = 1'b0;
        end
    end
endmodule

// File: rtl/sdmh_size_path.sv
module sdmh_size_path
    import sdmh_pkg::*;
#(
    parameter int EW = 8,
    localparam int NL = VEC_W / EW
) (
    input  logic             form_i,
    input  logic             rnd_i,
    input  logic [NL-1:0]    en_i,
    input  logic [EW-1:0]    scal_i,
    input  logic [VEC_W-1:0] dst_i,
    input  logic [VEC_W-1:0] src_i,
    output logic [VEC_W-1:0] res_o,
    output logic             sat_o
);
    logic [NL-1:0] sat_v;

    for (genvar k = 0; k < NL; k++) begin : g_lane
        logic [EW-1:0] d_l, y_l, a_l, hi_l;
        logic          s_l;

        assign d_l = dst_i[k*EW +: EW];
        assign y_l = form_i ? d_l : scal_i;
        assign a_l = form_i ? scal_i : d_l;

        sdmh_lane #(.EW(EW)) u_lane (
            .x_i   (src_i[k*EW +: EW]),
            .y_i   (y_l),
            .acc_i (a_l),
            .rnd_i (rnd_i),
            .hi_o  (hi_l),
            .sat_o (s_l)
        );

        assign res_o[k*EW +: EW] = en_i[k] ? hi_l : d_l;
        assign sat_v[k]          = en_i[k] & s_l;
    end

    assign sat_o = |sat_v;
endmodule

// File: rtl/sat_dbl_mac_hi.sv
module sat_dbl_mac_hi
    import sdmh_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    lane_sz,
    input  logic          form,
    input  logic          rnd,
    input  logic [15:0]   pred,
    input  logic [127:0]  dst_in,
    input  logic [127:0]  src_in,
    input  logic [31:0]   scalar_in,
    output logic [127:0]  res_out,
    output logic          res_valid,
    output logic          sat_sticky
);
    localparam int N8  = VEC_W / 8;
    localparam int N16 = VEC_W / 16;
    localparam int N32 = VEC_W / 32;

    sdmh_state_t state_d, state_q;

    logic [N8-1:0]    en8;
    logic [N16-1:0]   en16;
    logic [N32-1:0]   en32;
    logic [VEC_W-1:0] r8, r16, r32;
    logic             s8, s16, s32;

    // A lane is enabled by the predicate bit of its lowest byte.
    always_comb begin
        en8 = pred;
        for (int k = 0; k < N16; k++) en16[k] = pred[2*k];
        for (int k = 0; k < N32; k++) en32[k] = pred[4*k];
    end

    sdmh_size_path #(.EW(8)) u_p8 (
        .form_i (form), .rnd_i (rnd), .en_i (en8), .scal_i (scalar_in[7:0]),
        .dst_i (dst_in), .src_i (src_in), .res_o (r8), .sat_o (s8)
    );
    sdmh_size_path #(.EW(16)) u_p16 (
        .form_i (form), .rnd_i (rnd), .en_i (en16), .scal_i (scalar_in[15:0]),
        .dst_i (dst_in), .src_i (src_in), .res_o (r16), .sat_o (s16)
    );
    sdmh_size_path #(.EW(32)) u_p32 (
        .form_i (form), .rnd_i (rnd), .en_i (en32), .scal_i (scalar_in),
        .dst_i (dst_in), .src_i (src_in), .res_o (r32), .sat_o (s32)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            unique case (lane_sz_e'(lane_sz))
                SZ_B8: begin
                    state_d.res = r8;
                    state_d.stk = state_q.stk | s8;
                end
                SZ_B16: begin
                    state_d.res = r16;
                    state_d.stk = state_q.stk | s16;
                end
                default: begin
                    state_d.res = r32;
                    state_d.stk = state_q.stk | s32;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign res_out    = state_q.res;
    assign res_valid  = state_q.vld;
    assign sat_sticky = state_q.stk;
endmodule

// File: rtl/sdmh_chk.sv
module sdmh_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [1:0]   lane_sz,
    input logic         form,
    input logic         rnd,
    input logic [15:0]  pred,
    input logic [127:0] dst_in,
    input logic [127:0] src_in,
    input logic [31:0]  scalar_in,
    input logic [127:0] res_out,
    input logic         res_valid,
    input logic         sat_sticky
);
    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (res_out == '0 && !res_valid && !sat_sticky));

    assert_strobe_follow_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && $stable(res_out)));

    assert_sticky_keep_R9: assert property (@(posedge clk) disable iff (rst)
        sat_sticky |=> sat_sticky);

    assert_all_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pred == '0) |=>
            (res_out == $past(dst_in) && sat_sticky == $past(sat_sticky)));

    assert_byte_lane_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_sz == 2'd0 && !pred[0]) |=>
            (res_out[7:0] == $past(dst_in[7:0])));
endmodule

bind sat_dbl_mac_hi sdmh_chk u_sdmh_chk (.*);

// File: tb/test_sat_dbl_mac_hi.sv
`timescale 1ns/1ps
module test_sat_dbl_mac_hi;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   lane_sz = 2'd0;
    logic         form = 1'b0;
    logic         rnd = 1'b0;
    logic [15:0]  pred = '0;
    logic [127:0] dst_in = '0;
    logic [127:0] src_in = '0;
    logic [31:0]  scalar_in = '0;
    logic [127:0] res_out;
    logic         res_valid;
    logic         sat_sticky;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sat_dbl_mac_hi i_sat_dbl_mac_hi (.*);

    function automatic logic signed [71:0] sext(input logic [127:0] v, input int e);
        logic signed [127:0] t;
        t = v << (128 - e);
        t = t >>> (128 - e);
        return t[71:0];
    endfunction

    function automatic void ref_vec(input logic [1:0] esz, input logic frm, input logic rn,
                                    input logic [15:0] pr, input logic [127:0] d,
                                    input logic [127:0] s, input logic [31:0] sc,
                                    output logic [127:0] r, output logic st);
        int e;
        logic signed [71:0] x, y, a, w, lim;
        logic [127:0] lane, em;
        e  = (esz == 2'd0) ? 8 : (esz == 2'd1) ? 16 : 32;
        em = (128'd1 << e) - 128'd1;
        r  = d;
        st = 1'b0;
        for (int k = 0; k < 128 / e; k++) begin
            x = sext(s >> (k * e), e);
            if (!frm) begin
                y = sext(128'(sc), e);
                a = sext(d >> (k * e), e);
            end else begin
                y = sext(d >> (k * e), e);
                a = sext(128'(sc), e);
            end
            w = 2 * x * y + (a <<< e) + (rn ? (72'sd1 <<< (e - 1)) : 72'sd0);
            lim = 72'sd1 <<< (2 * e - 1);
            if (pr[k * e / 8]) begin
                if (w >= lim) begin
                    lane = (128'd1 << (e - 1)) - 128'd1;
                    st = 1'b1;
                end else if (w < -lim) begin
                    lane = 128'd1 << (e - 1);
                    st = 1'b1;
                end else begin
                    lane = 128'(w >>> e);
                end
                r = (r & ~(em << (k * e))) | ((lane & em) << (k * e));
            end
        end
    endfunction

    // Behavioural model, updated on the same edge as the design.
    logic [127:0] m_res = '0;
    logic         m_vld = 1'b0;
    logic         m_stk = 1'b0;
    logic [127:0] t_res;
    logic         t_sat;

    always @(posedge clk) begin
        if (rst) begin
            m_res <= '0; m_vld <= 1'b0; m_stk <= 1'b0;
        end else begin
            m_vld <= in_valid;
            if (in_valid) begin
                ref_vec(lane_sz, form, rnd, pred, dst_in, src_in, scalar_in, t_res, t_sat);
                m_res <= t_res;
                if (t_sat) m_stk <= 1'b1;
            end
        end
    end

    // Cycle-by-cycle comparison against the model (R2 R3 R4 R5 R7 R10 model check).
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (res_out !== m_res || res_valid !== m_vld || sat_sticky !== m_stk) begin
                errors++;
                $display("FAIL R2 R3 R4 R5 R7 R10 model: res=%h vld=%b stk=%b expected res=%h vld=%b stk=%b",
                         res_out, res_valid, sat_sticky, m_res, m_vld, m_stk);
            end
        end
    end

    task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [1:0] esz, input logic frm, input logic rn,
                         input logic [15:0] pr, input logic [127:0] d,
                         input logic [127:0] s, input logic [31:0] sc);
        @(negedge clk);
        lane_sz = esz; form = frm; rnd = rn; pred = pr;
        dst_in = d; src_in = s; scalar_in = sc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] pick_word();
        case ($urandom_range(0, 5))
            0: return 32'h80808080;
            1: return 32'h7F7F7F7F;
            2: return 32'h80008000;
            3: return 32'h7FFF8000;
            4: return 32'h00000000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset res", res_out, '0);
        chk("R11 reset flags", {126'd0, res_valid, sat_sticky}, '0);
        @(negedge clk);
        rst = 1'b0;

        // R2: 8-bit, scalar-multiplier form: 2*64*64 + (1<<8) = 8448 -> 0x21
        apply(2'd0, 1'b0, 1'b0, 16'hFFFF, {16{8'h01}}, {16{8'h40}}, 32'h00000040);
        chk("R2 form0 8-bit", res_out, {16{8'h21}});
        chk("R10 strobe", {127'd0, res_valid}, 128'd1);

        // R4: 2*64*1 = 128 -> 0 without rounding, 1 with rounding
        apply(2'd0, 1'b0, 1'b0, 16'hFFFF, '0, {16{8'h40}}, 32'h00000001);
        chk("R4 no round", res_out, '0);
        apply(2'd0, 1'b0, 1'b1, 16'hFFFF, '0, {16{8'h40}}, 32'h00000001);
        chk("R4 round", res_out, {16{8'h01}});

        // R3 + R7: 16-bit, scalar-addend form, upper scalar bits ignored
        apply(2'd1, 1'b1, 1'b0, 16'hFFFF, {8{16'h2000}}, {8{16'h4000}}, 32'hABCD0003);
        chk("R3 R7 form1 16-bit", res_out, {8{16'h1003}});

        // R8: 32-bit lanes, only lanes 0 and 2 enabled (bits 0 and 8 set)
        apply(2'd2, 1'b0, 1'b0, 16'hE1E1,
              {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111},
              {4{32'h00010000}}, 32'h00010000);
        chk("R8 lane mask", res_out, {32'h44444444, 32'h33333335, 32'h22222222, 32'h11111113});

        // R1: code 3 behaves as 32-bit
        apply(2'd3, 1'b0, 1'b0, 16'hE1E1,
              {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111},
              {4{32'h00010000}}, 32'h00010000);
        chk("R1 code3 32-bit", res_out, {32'h44444444, 32'h33333335, 32'h22222222, 32'h11111113});

        // R9: saturating lane 0 disabled, flag stays clear
        apply(2'd0, 1'b0, 1'b0, 16'hFFFE, '0, {120'd0, 8'h80}, 32'h00000080);
        chk("R9 disabled sat result", res_out, '0);
        chk("R9 disabled sat flag", {127'd0, sat_sticky}, '0);

        // R6: 32-bit, rounding brings -2^63-2^31 back to -2^63: no saturation
        apply(2'd2, 1'b1, 1'b1, 16'hFFFF, {4{32'h00008000}}, {4{32'hFFFF8000}}, 32'h80000000);
        chk("R6 round recover", res_out, {4{32'h80000000}});
        chk("R6 round recover flag", {127'd0, sat_sticky}, '0);
        apply(2'd2, 1'b1, 1'b0, 16'hFFFF, {4{32'h00008000}}, {4{32'hFFFF8000}}, 32'h80000000);
        chk("R6 no round saturates", res_out, {4{32'h80000000}});
        chk("R6 R9 flag set", {127'd0, sat_sticky}, 128'd1);

        // R5: positive and negative clamps at 8 bits
        apply(2'd0, 1'b0, 1'b0, 16'hFFFF, '0, {16{8'h80}}, 32'h00000080);
        chk("R5 positive clamp", res_out, {16{8'h7F}});
        apply(2'd0, 1'b0, 1'b0, 16'hFFFF, {16{8'h80}}, {16{8'h80}}, 32'h0000007F);
        chk("R5 negative clamp", res_out, {16{8'h80}});

        // R9: non-saturating op does not clear flag
        apply(2'd1, 1'b0, 1'b0, 16'hFFFF, '0, '0, 32'h0);
        chk("R9 flag held", {127'd0, sat_sticky}, 128'd1);

        // R10: idle cycle with changed inputs holds result, valid low
        @(negedge clk);
        dst_in = {4{32'hDEADBEEF}}; src_in = {4{32'h12345678}};
        @(negedge clk);
        chk("R10 idle hold", res_out, '0);
        chk("R10 idle valid", {127'd0, res_valid}, '0);

        // Random phase compared against model each cycle
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            in_valid = ($urandom_range(0, 3) != 0);
            lane_sz = 2'($urandom_range(0, 3));
            form = 1'($urandom);
            rnd = 1'($urandom);
            pred = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
            for (int w = 0; w < 4; w++) begin
                dst_in[w*32 +: 32] = pick_word();
                src_in[w*32 +: 32] = pick_word();
            end
            scalar_in = pick_word();
        end
        @(negedge clk);
        in_valid = 1'b0;

        // R11: reset clears everything again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 second reset", {res_out, 6'd0, res_valid, sat_sticky}, '0);

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule